// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the fetch half of a processor whose bus side and execution side run side by side. It keeps a small queue of instruction bytes topped up from memory while the execution side drains bytes from the front, so fetching and executing overlap. Fetches go out one byte at a time from a flat fetch pointer that advances after every fetch it issues.

The execution side has three things it can do. It pops one or two bytes from the head; a byte count tells it how many are waiting. It redirects fetch to a new target on a taken jump, which empties the queue. It asks for a data read, which takes the bus ahead of any prefetch that has not yet started. The memory side sees one request at a time. Each request has an address and a flag that marks data cycles. The request ends in the cycle where ready is high, and the read byte is valid in that same cycle.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is high, and in the first cycle after it, the queue holds zero bytes and no bus request is active. The first request after reset is a prefetch from address RESET_PC.
- R2: Prefetch addresses increase by one for each fetch issued. The bytes leave the head in that address order, with no gaps and no repeats.
- R3: The head byte appears on q_byte0 and the byte after it on q_byte1. q_count gives the number of queued bytes, never exceeds DEPTH, and rises by at most one per cycle.
- R4: While q_count equals DEPTH, no prefetch cycle is on the bus. After one byte is popped from a full queue, a new prefetch starts at the next clock edge.
- R5: pop_req with pop_two=0 removes one byte, and with pop_two=1 removes two. A pop that asks for more bytes than q_count holds removes nothing, and the head byte stays the same.
- R6: A data read that is raised while the bus is idle starts at the next edge, with mem_data_cyc=1 and mem_addr equal to data_addr. data_done pulses in its completing cycle, with data_rdata equal to the byte read. Prefetch then resumes at the address where it stopped.
- R7: A data read that is raised while a prefetch is outstanding waits for that prefetch to complete. The data cycle then starts at the very next edge, ahead of any further prefetch.
- R8: A flush empties the queue at the next edge, so q_count reads 0 in the cycle that follows. A pop made in the flush cycle is ignored. Later bytes come from flush_target onward.
- R9: A prefetch that is outstanding when a flush occurs still finishes on the bus, but its byte is thrown away and never reaches the queue.
- R10: Once a request is raised, mem_req, mem_addr and mem_data_cyc hold steady until the cycle in which mem_rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Bus request active |
| mem_addr | output | AW | Bus byte address |
| mem_data_cyc | output | 1 | 1 = data read cycle, 0 = prefetch cycle |
| mem_rdy | input | 1 | Request completes this cycle |
| mem_rdata | input | 8 | Read byte, valid when mem_rdy is high |
| q_byte0 | output | 8 | Byte at the queue head |
| q_byte1 | output | 8 | Byte after the head |
| q_count | output | clog2(DEPTH+1) | Bytes held in the queue |
| pop_req | input | 1 | Pop from the head |
| pop_two | input | 1 | Pop two bytes instead of one |
| flush | input | 1 | Discard the queue and redirect fetch |
| flush_target | input | AW | New fetch address |
| data_req | input | 1 | Data read request, held until data_done |
| data_addr | input | AW | Data read address |
| data_done | output | 1 | Data read completes this cycle |
| data_rdata | output | 8 | Data read byte |

## Verification
The properties assume that the execution side keeps data_req high until it sees data_done, drops it right after, and holds data_addr stable meanwhile. They also assume that the memory answers every request within a few cycles. The stimulus raises and lowers data_req only between clock edges, one request at a time. It runs a bus model whose wait states are swept from zero to three. Pops are issued only when q_count covers them, except in the one test that probes an over-sized pop on purpose.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_FETCH = 2'd1,
        OWN_DATA  = 2'd2
    } bus_own_e;

    typedef struct packed {
        logic push;
        logic clear;
        logic [1:0] pop_n;
    } q_ctl_t;

    // Circular index advance for depths that need not be a power of two.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned step,
                                              int unsigned depth);
        int unsigned s;
        s = idx + step;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/pfq_queue.sv
module pfq_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  q_ctl_t                         ctl,
    input  logic [7:0]                     wbyte,
    output logic [7:0]                     head0,
    output logic [7:0]                     head1,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int unsigned IW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [7:0]    store [DEPTH];
    logic [IW-1:0] head_q, tail_q;

    always_ff @(posedge clk) begin
        if (ctl.push && !ctl.clear) store[tail_q] <= wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (ctl.push)
                tail_q <= IW'(ring_next(int'(tail_q), 1, DEPTH));
            if (ctl.pop_n != 2'd0)
                head_q <= IW'(ring_next(int'(head_q), int'(ctl.pop_n), DEPTH));
            count <= count + CW'(ctl.push) - CW'(ctl.pop_n);
        end
    end

    assign head0 = store[head_q];
    assign head1 = store[IW'(ring_next(int'(head_q), 1, DEPTH))];

endmodule

// File: rtl/pfq_bus_arb.sv
module pfq_bus_arb
    import pfq_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mem_rdy,
    input  logic          data_req,
    input  logic [AW-1:0] data_addr,
    input  logic          fetch_ok,
    input  logic [AW-1:0] fetch_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_data_cyc,
    output logic          done_fetch,
    output logic          done_data,
    output logic          launch_fetch
);
    bus_own_e      own_q;
    logic [AW-1:0] addr_q;
    logic          done, free, launch_data;

    assign done        = (own_q != OWN_IDLE) && mem_rdy;
    assign free        = (own_q == OWN_IDLE) || done;
    // Data wins whenever the bus frees up; a finishing data cycle is not relaunched.
    assign launch_data = free && data_req && (own_q != OWN_DATA);
    assign launch_fetch = free && !launch_data && fetch_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= OWN_IDLE;
            addr_q <= '0;
        end else if (free) begin
            if (launch_data) begin
                own_q  <= OWN_DATA;
                addr_q <= data_addr;
            end else if (launch_fetch) begin
                own_q  <= OWN_FETCH;
                addr_q <= fetch_addr;
            end else begin
                own_q  <= OWN_IDLE;
            end
        end
    end

    assign mem_req      = (own_q != OWN_IDLE);
    assign mem_addr     = addr_q;
    assign mem_data_cyc = (own_q == OWN_DATA);
    assign done_fetch   = done && (own_q == OWN_FETCH);
    assign done_data    = done && (own_q == OWN_DATA);

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH    = 6,
    parameter int unsigned AW       = 20,
    parameter int unsigned RESET_PC = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    output logic                       mem_data_cyc,
    input  logic                       mem_rdy,
    input  logic [7:0]                 mem_rdata,
    output logic [7:0]                 q_byte0,
    output logic [7:0]                 q_byte1,
    output logic [$clog2(DEPTH+1)-1:0] q_count,
    input  logic                       pop_req,
    input  logic                       pop_two,
    input  logic                       flush,
    input  logic [AW-1:0]              flush_target,
    input  logic                       data_req,
    input  logic [AW-1:0]              data_addr,
    output logic                       data_done,
    output logic [7:0]                 data_rdata
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [AW-1:0] fptr_q, fetch_addr;
    logic          drop_q;
    logic          done_fetch, done_data, launch_fetch, fetch_ok;
    logic [1:0]    want_n;
    logic [CW:0]   count_after;
    q_ctl_t        qctl;

    assign want_n     = pop_two ? 2'd2 : 2'd1;
    assign qctl.clear = flush;
    assign qctl.push  = done_fetch && !drop_q && !flush;
    assign qctl.pop_n = (pop_req && !flush && (q_count >= CW'(want_n))) ? want_n : 2'd0;

    // Occupancy after this edge decides whether another prefetch may start.
    assign count_after = flush ? '0
                       : (CW+1)'(q_count) + (CW+1)'(qctl.push) - (CW+1)'(qctl.pop_n);
    assign fetch_ok    = (count_after < (CW+1)'(DEPTH));
    assign fetch_addr  = flush ? flush_target : fptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fptr_q <= AW'(RESET_PC);
            drop_q <= 1'b0;
        end else begin
            if (launch_fetch)
                fptr_q <= fetch_addr + AW'(1);
            else if (flush)
                fptr_q <= flush_target;
            if (flush && mem_req && !mem_data_cyc && !mem_rdy)
                drop_q <= 1'b1;
            else if (done_fetch)
                drop_q <= 1'b0;
        end
    end

    pfq_queue #(.DEPTH(DEPTH)) queue_i (
        .clk   (clk),
        .rst   (rst),
        .ctl   (qctl),
        .wbyte (mem_rdata),
        .head0 (q_byte0),
        .head1 (q_byte1),
        .count (q_count)
    );

    pfq_bus_arb #(.AW(AW)) arb_i (
        .clk          (clk),
        .rst          (rst),
        .mem_rdy      (mem_rdy),
        .data_req     (data_req),
        .data_addr    (data_addr),
        .fetch_ok     (fetch_ok),
        .fetch_addr   (fetch_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_data_cyc (mem_data_cyc),
        .done_fetch   (done_fetch),
        .done_data    (done_data),
        .launch_fetch (launch_fetch)
    );

    assign data_done  = done_data;
    assign data_rdata = mem_rdata;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned AW    = 20
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       mem_req,
    input logic [AW-1:0]              mem_addr,
    input logic                       mem_data_cyc,
    input logic                       mem_rdy,
    input logic [$clog2(DEPTH+1)-1:0] q_count,
    input logic                       flush,
    input logic                       data_req,
    input logic                       data_done
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(q_count) <= int'(DEPTH)); // R3

    AST_GROWTH_ONE: assert property (@(posedge clk) disable iff (rst)
        !flush |=> int'(q_count) <= int'($past(q_count)) + 1); // R3

    AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        int'(q_count) == int'(DEPTH) |-> !(mem_req && !mem_data_cyc)); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> q_count == '0); // R8

    AST_DATA_NEXT: assert property (@(posedge clk) disable iff (rst)
        data_req && !data_done && mem_req && !mem_data_cyc && mem_rdy |=> mem_req && mem_data_cyc); // R7

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_data_cyc)); // R10

endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_data_cyc (mem_data_cyc),
    .mem_rdy      (mem_rdy),
    .q_count      (q_count),
    .flush        (flush),
    .data_req     (data_req),
    .data_done    (data_done)
);

// File: tb/prefetch_queue_tb_top.sv
module prefetch_queue_tb_top;
    localparam int unsigned DEPTH = 6;
    localparam int unsigned AW    = 20;
    localparam int unsigned RPC   = 20'h0FFF8;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          mem_req, mem_data_cyc, mem_rdy, data_done;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata, q_byte0, q_byte1, data_rdata;
    logic [CW-1:0] q_count;
    logic          pop_req = 0, pop_two = 0, flush = 0, data_req = 0;
    logic [AW-1:0] flush_target = '0, data_addr = '0;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    int wcnt   = 0;
    logic [AW-1:0] exp_pc;

    function automatic logic [7:0] fbyte(logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Bus model: completes a request after lat wait cycles.
    assign mem_rdy   = mem_req && (wcnt >= lat);
    assign mem_rdata = fbyte(mem_addr);
    always @(posedge clk) begin
        if (rst || (mem_req && mem_rdy)) wcnt <= 0;
        else if (mem_req) wcnt <= wcnt + 1;
    end

    prefetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_PC(RPC)) dut_i (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_data_cyc(mem_data_cyc), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
        .q_byte0(q_byte0), .q_byte1(q_byte1), .q_count(q_count),
        .pop_req(pop_req), .pop_two(pop_two), .flush(flush), .flush_target(flush_target),
        .data_req(data_req), .data_addr(data_addr), .data_done(data_done),
        .data_rdata(data_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // mode 0: single pops, 1: double pops, 2: alternating
    task automatic consume(input int npops, input int mode);
        int k = 0;
        for (int cyc = 0; cyc < 400 && k < npops; cyc++) begin
            int n = (mode == 0) ? 1 : (mode == 1) ? 2 : (k % 2) + 1;
            if (int'(q_count) >= n) begin
                check(q_byte0 == fbyte(exp_pc), "R2 head byte", q_byte0, fbyte(exp_pc));
                if (n == 2)
                    check(q_byte1 == fbyte(exp_pc + 1), "R3 second byte", q_byte1, fbyte(exp_pc + 1));
                pop_req = 1; pop_two = (n == 2);
                exp_pc  = exp_pc + AW'(n);
                k++;
            end else begin
                pop_req = 0;
            end
            @(negedge clk);
        end
        pop_req = 0; pop_two = 0;
        check(k == npops, "R2 pop progress", k, npops);
    endtask

    task automatic wait_full();
        for (int c = 0; c < 100 && int'(q_count) != DEPTH; c++) @(negedge clk);
    endtask

    task automatic do_flush(input logic [AW-1:0] tgt);
        bit inflight;
        logic [AW-1:0] held;
        inflight = mem_req && !mem_data_cyc && !mem_rdy;
        held = mem_addr;
        flush = 1; flush_target = tgt; pop_req = 1; pop_two = 0;
        @(negedge clk);
        flush = 0; pop_req = 0;
        check(q_count == 0, "R8 flush empties", q_count, 0);
        if (inflight)
            check(mem_req && mem_addr == held, "R9 in-flight fetch kept on bus", mem_addr, held);
        exp_pc = tgt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        exp_pc = AW'(RPC);
        repeat (3) @(negedge clk);
        check(q_count == 0 && !mem_req, "R1 reset state", {q_count, mem_req}, 0);
        rst = 0;
        check(q_count == 0 && !mem_req, "R1 first cycle after reset", {q_count, mem_req}, 0);
        @(negedge clk);
        check(mem_req && !mem_data_cyc && mem_addr == AW'(RPC), "R1 first fetch address", mem_addr, RPC);

        // Sweep wait states and pop patterns.
        for (int l = 0; l < 4; l++) begin
            lat = l;
            wait_full();
            check(int'(q_count) == DEPTH, "R4 queue fills", q_count, DEPTH);
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                check(!(mem_req && !mem_data_cyc), "R4 stall when full", mem_req, 0);
            end
            check(q_byte0 == fbyte(exp_pc) && q_byte1 == fbyte(exp_pc + 1), "R3 head pair",
                  {q_byte0, q_byte1}, {fbyte(exp_pc), fbyte(exp_pc + 1)});
            pop_req = 1; pop_two = 0; exp_pc = exp_pc + 1;
            @(negedge clk);
            pop_req = 0;
            check(mem_req && !mem_data_cyc, "R4 resume after pop", mem_req, 1);
            for (int m = 0; m < 3; m++) consume(20, m);
        end

        // Flush with fetch in flight and with fetch completing.
        for (int l = 0; l < 4; l++) begin
            lat = l;
            consume(3, 0);
            for (int c = 0; c < 10 && !(mem_req && !mem_data_cyc); c++) @(negedge clk);
            do_flush(AW'(20'h3A000 + l * 20'h100));
            consume(12, 2);
        end

        // Over-sized pop.
        lat = 3;
        do_flush(20'h05550);
        for (int c = 0; c < 20 && q_count != 1; c++) @(negedge clk);
        check(q_count == 1, "R5 single byte present", q_count, 1);
        pop_req = 1; pop_two = 1;
        @(negedge clk);
        pop_req = 0; pop_two = 0;
        check(q_count >= 1 && q_byte0 == fbyte(exp_pc), "R5 over-pop ignored", q_byte0, fbyte(exp_pc));
        consume(8, 1);

        // Data read while a prefetch is outstanding.
        lat = 2;
        for (int c = 0; c < 20 && !(mem_req && !mem_data_cyc && !mem_rdy); c++) @(negedge clk);
        data_addr = 20'h7C3D1; data_req = 1;
        begin
            bit seen_done = 0;
            for (int c = 0; c < 20 && !(mem_req && !mem_data_cyc && mem_rdy); c++) @(negedge clk);
            @(negedge clk);
            check(mem_req && mem_data_cyc && mem_addr == 20'h7C3D1, "R7 data next after prefetch",
                  mem_addr, 20'h7C3D1);
            for (int c = 0; c < 20 && !seen_done; c++) begin
                if (data_done) begin
                    seen_done = 1;
                    check(data_rdata == fbyte(20'h7C3D1), "R6 data byte", data_rdata, fbyte(20'h7C3D1));
                    data_req = 0;
                end
                @(negedge clk);
            end
            check(seen_done, "R6 data completes", seen_done, 1);
        end
        consume(14, 2);

        // Data read while the bus is idle (queue full).
        for (int l = 0; l < 4; l += 3) begin
            lat = l;
            wait_full();
            data_addr = AW'(20'h12345 + l); data_req = 1;
            @(negedge clk);
            check(mem_req && mem_data_cyc && mem_addr == data_addr, "R6 data starts when idle",
                  mem_addr, data_addr);
            for (int c = 0; c < 10 && !data_done; c++) @(negedge clk);
            check(data_done && data_rdata == fbyte(data_addr), "R6 data byte idle",
                  data_rdata, fbyte(data_addr));
            data_req = 0;
            @(negedge clk);
            consume(16, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule